// File: doc/BRIEF.md
# Energy Pulse Source Selector

This block chooses the values that feed the two energy pulse-rate generators of a metering datapath. Each accumulation interval it latches one pair of values: a real-power value and a reactive-power value. Under host control, it takes four host-written rate words: the real and reactive values plus two auxiliary rates. Under internal control, it forms the pair from the per-element energy sums. In summing mode it adds the two elements. Otherwise it takes the element that carries the larger squared-current sum.

The selection is captured on the interval-done strobe and held until the next strobe, so the generators see a constant rate through each interval. A creep-halt input forces every output to zero while it is high. The latched values remain inside the block and appear again when the halt drops.

Top module: `pulse_src_sel`

## Requirements
- R1: After reset, `real_o`, `react_o`, `aux_a_o` and `aux_b_o` are all zero.
- R2: With `ext_ctrl_i`=1 at a strobe, `real_o` and `react_o` take `mpu_real_i` and `mpu_react_i` from the next cycle.
- R3: With `ext_ctrl_i`=1 at a strobe, `aux_a_o`/`aux_b_o` take `mpu_aux_a_i`/`mpu_aux_b_i`; with `ext_ctrl_i`=0 at a strobe, both become zero.
- R4: With internal control and `eq_mode_i`=2, `real_o` equals the two's-complement sum of `real0_i` and `real1_i`, and `react_o` equals the sum of `react0_i` and `react1_i`, each one bit wider than the inputs so that no overflow occurs.
- R5: With internal control, `eq_mode_i`=0 and `isq0_i` > `isq1_i` (unsigned), `real_o`/`react_o` are `real0_i`/`react0_i` sign-extended by one bit.
- R6: With internal control, `eq_mode_i`=0 and `isq1_i` > `isq0_i`, `real_o`/`react_o` are `real1_i`/`react1_i` sign-extended.
- R7: With internal control, `eq_mode_i`=0 and equal squared-current sums, element 0 is selected.
- R8: The `eq_mode_i` codes 1 and 3 behave like code 0.
- R9: Without a strobe, the outputs keep their values whatever the data and mode inputs do.
- R10: While `creep_halt_i` is 1, all four outputs are zero in both control modes. A strobe during the halt still captures the new values, and these appear when the halt drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interval_done_i | input | 1 | One-cycle strobe at the end of each accumulation interval |
| ext_ctrl_i | input | 1 | 1: host-written rates, 0: internal derivation |
| eq_mode_i | input | 2 | 2: sum both elements; any other code: pick by squared current |
| creep_halt_i | input | 1 | Forces all outputs to zero while high |
| real0_i | input | SUM_W | Element 0 real-energy sum (signed) |
| real1_i | input | SUM_W | Element 1 real-energy sum (signed) |
| react0_i | input | SUM_W | Element 0 reactive-energy sum (signed) |
| react1_i | input | SUM_W | Element 1 reactive-energy sum (signed) |
| isq0_i | input | SQ_W | Element 0 squared-current sum (unsigned) |
| isq1_i | input | SQ_W | Element 1 squared-current sum (unsigned) |
| mpu_real_i | input | SUM_W+1 | Host real-power rate |
| mpu_react_i | input | SUM_W+1 | Host reactive-power rate |
| mpu_aux_a_i | input | SUM_W+1 | Host auxiliary rate A |
| mpu_aux_b_i | input | SUM_W+1 | Host auxiliary rate B |
| real_o | output | SUM_W+1 | Real-power value to the first generator |
| react_o | output | SUM_W+1 | Reactive-power value to the second generator |
| aux_a_o | output | SUM_W+1 | Auxiliary rate A |
| aux_b_o | output | SUM_W+1 | Auxiliary rate B |

## Verification
The bench builds the block with SUM_W=16 and SQ_W=12. With these widths, the extreme cases can be written as short literals: two most-positive sums whose total needs the seventeenth bit, two most-negative sums, and squared-current values at 0 and full scale on opposite elements. The narrow widths also make sign-extension errors in the picked element visible when bit 15 is set. The bench can then observe the hold behaviour and the creep release with a few cycles of stimulus.

// File: rtl/pulse_src_pkg.sv
package pulse_src_pkg;
  typedef enum logic [1:0] {
    EQ_PICK0 = 2'd0,
    EQ_PICK1 = 2'd1,
    EQ_SUM   = 2'd2,
    EQ_PICK3 = 2'd3
  } eq_mode_e;

  localparam int unsigned NUM_CH = 2;  // real, reactive
endpackage

// File: rtl/pulse_src_pick.sv
module pulse_src_pick #(
  parameter int SQ_W = 32
) (
  input  logic [SQ_W-1:0] isq0_i,
  input  logic [SQ_W-1:0] isq1_i,
  output logic            pick1_o
);
  // ties stay on element 0
  always_comb pick1_o = isq1_i > isq0_i;
endmodule

// File: rtl/pulse_src_chan.sv
module pulse_src_chan #(
  parameter int SUM_W = 32,
  localparam int OUT_W = SUM_W + 1
) (
  input  logic [SUM_W-1:0] e0_i,
  input  logic [SUM_W-1:0] e1_i,
  input  logic             sum_mode_i,
  input  logic             pick1_i,
  output logic [OUT_W-1:0] val_o
);
  logic [OUT_W-1:0] e0_x, e1_x;

  always_comb begin
    e0_x = {e0_i[SUM_W-1], e0_i};
    e1_x = {e1_i[SUM_W-1], e1_i};
    if (sum_mode_i)   val_o = e0_x + e1_x;
    else if (pick1_i) val_o = e1_x;
    else              val_o = e0_x;
  end
endmodule

// File: rtl/pulse_src_hold.sv
module pulse_src_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o)); // R9

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(d_i)); // R2
endmodule

// File: rtl/pulse_src_sel.sv
module pulse_src_sel
  import pulse_src_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int SQ_W  = 32,
  localparam int OUT_W = SUM_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             interval_done_i,
  input  logic             ext_ctrl_i,
  input  logic [1:0]       eq_mode_i,
  input  logic             creep_halt_i,
  input  logic [SUM_W-1:0] real0_i,
  input  logic [SUM_W-1:0] real1_i,
  input  logic [SUM_W-1:0] react0_i,
  input  logic [SUM_W-1:0] react1_i,
  input  logic [SQ_W-1:0]  isq0_i,
  input  logic [SQ_W-1:0]  isq1_i,
  input  logic [OUT_W-1:0] mpu_real_i,
  input  logic [OUT_W-1:0] mpu_react_i,
  input  logic [OUT_W-1:0] mpu_aux_a_i,
  input  logic [OUT_W-1:0] mpu_aux_b_i,
  output logic [OUT_W-1:0] real_o,
  output logic [OUT_W-1:0] react_o,
  output logic [OUT_W-1:0] aux_a_o,
  output logic [OUT_W-1:0] aux_b_o
);
  localparam int NUM_OUT = 4;
  localparam int HOLD_W  = NUM_OUT * OUT_W;

  eq_mode_e eq_mode;
  logic     sum_mode;
  logic     pick1;

  logic [NUM_CH-1:0][SUM_W-1:0] e0_arr, e1_arr;
  logic [NUM_CH-1:0][OUT_W-1:0] int_val;
  logic [NUM_CH-1:0][OUT_W-1:0] mpu_main;
  logic [NUM_OUT-1:0][OUT_W-1:0] next_val, held_val;

  always_comb begin
    eq_mode  = eq_mode_e'(eq_mode_i);
    sum_mode = (eq_mode == EQ_SUM);
    e0_arr   = {react0_i, real0_i};
    e1_arr   = {react1_i, real1_i};
    mpu_main = {mpu_react_i, mpu_real_i};
  end

  pulse_src_pick #(.SQ_W(SQ_W)) u_pick (
    .isq0_i  (isq0_i),
    .isq1_i  (isq1_i),
    .pick1_o (pick1)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pulse_src_chan #(.SUM_W(SUM_W)) u_chan (
      .e0_i       (e0_arr[ch]),
      .e1_i       (e1_arr[ch]),
      .sum_mode_i (sum_mode),
      .pick1_i    (pick1),
      .val_o      (int_val[ch])
    );
  end

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++)
      next_val[ch] = ext_ctrl_i ? mpu_main[ch] : int_val[ch];
    next_val[2] = ext_ctrl_i ? mpu_aux_a_i : '0;
    next_val[3] = ext_ctrl_i ? mpu_aux_b_i : '0;
  end

  pulse_src_hold #(.W(HOLD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (interval_done_i),
    .d_i    (next_val),
    .q_o    (held_val)
  );

  // creep halt gates outputs only; held state survives
  always_comb begin
    real_o  = creep_halt_i ? '0 : held_val[0];
    react_o = creep_halt_i ? '0 : held_val[1];
    aux_a_o = creep_halt_i ? '0 : held_val[2];
    aux_b_o = creep_halt_i ? '0 : held_val[3];
  end

  AST_EXT_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_done_i && ext_ctrl_i) |=>
      (creep_halt_i || real_o == $past(mpu_real_i))); // R2

  AST_AUX_INT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_done_i && !ext_ctrl_i) |=> (aux_a_o == '0 && aux_b_o == '0)); // R3

  AST_SUM_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_done_i && !ext_ctrl_i && eq_mode_i == 2'd2) |=>
      (creep_halt_i || $signed(real_o) ==
        $signed({$past(real0_i[SUM_W-1]), $past(real0_i)}) +
        $signed({$past(real1_i[SUM_W-1]), $past(real1_i)}))); // R4

  AST_TIE_ELEM0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_done_i && !ext_ctrl_i && eq_mode_i != 2'd2 && isq0_i == isq1_i) |=>
      (creep_halt_i || real_o == {$past(real0_i[SUM_W-1]), $past(real0_i)})); // R7

  AST_CREEP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    creep_halt_i |-> (real_o == '0 && react_o == '0 &&
                      aux_a_o == '0 && aux_b_o == '0)); // R10
endmodule

// File: tb/tb_pulse_src_sel.sv
`timescale 1ns/1ps
module tb_pulse_src_sel;
  localparam int SUM_W = 16;
  localparam int SQ_W  = 12;
  localparam int OUT_W = SUM_W + 1;

  typedef struct {
    logic [OUT_W-1:0] re, rx, aa, ab;
    string            tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic strobe = 0, ext = 0, creep = 0;
  logic [1:0] eqm = 0;
  logic [SUM_W-1:0] r0 = 0, r1 = 0, x0 = 0, x1 = 0;
  logic [SQ_W-1:0]  q0 = 0, q1 = 0;
  logic [OUT_W-1:0] mr = 0, mx = 0, ma = 0, mb = 0;
  logic [OUT_W-1:0] real_o, react_o, aux_a_o, aux_b_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];
  exp_t last;

  always #10 clk = ~clk;

  pulse_src_sel #(.SUM_W(SUM_W), .SQ_W(SQ_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .interval_done_i(strobe), .ext_ctrl_i(ext),
    .eq_mode_i(eqm), .creep_halt_i(creep),
    .real0_i(r0), .real1_i(r1), .react0_i(x0), .react1_i(x1),
    .isq0_i(q0), .isq1_i(q1),
    .mpu_real_i(mr), .mpu_react_i(mx), .mpu_aux_a_i(ma), .mpu_aux_b_i(mb),
    .real_o(real_o), .react_o(react_o), .aux_a_o(aux_a_o), .aux_b_o(aux_b_o)
  );

  function automatic logic [OUT_W-1:0] sx(input logic [SUM_W-1:0] v);
    return {v[SUM_W-1], v};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input exp_t e);
    chk(e.tag, "real_o", real_o, e.re);
    chk(e.tag, "react_o", react_o, e.rx);
    chk(e.tag, "aux_a_o", aux_a_o, e.aa);
    chk(e.tag, "aux_b_o", aux_b_o, e.ab);
  endtask

  // expected value from the requirements, not from the design
  function automatic exp_t model(input string tag);
    exp_t e;
    e.tag = tag;
    if (ext) begin
      e.re = mr; e.rx = mx; e.aa = ma; e.ab = mb;
    end else begin
      e.aa = '0; e.ab = '0;
      if (eqm == 2'd2) begin
        e.re = sx(r0) + sx(r1);
        e.rx = sx(x0) + sx(x1);
      end else if (q1 > q0) begin
        e.re = sx(r1); e.rx = sx(x1);
      end else begin
        e.re = sx(r0); e.rx = sx(x0);
      end
    end
    return e;
  endfunction

  // driver: inputs already set, pulses the strobe and pushes the expectation
  task automatic fire(input string tag);
    exp_t e;
    @(negedge clk);
    e = model(tag);
    last = e;
    if (creep) begin
      e.re = '0; e.rx = '0; e.aa = '0; e.ab = '0;
    end
    sb.push_back(e);
    strobe = 1;
    @(negedge clk);
    strobe = 0;
    repeat (2) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (strobe && rst_n) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL scoreboard: actual empty expected item");
        end else chk_all(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t z;
    repeat (3) @(negedge clk);
    z.re = '0; z.rx = '0; z.aa = '0; z.ab = '0; z.tag = "R1";
    chk_all(z);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 host rates
    ext = 1; mr = 17'h12345; mx = 17'h00777; ma = 17'h00055; mb = 17'h1FFFF;
    fire("R2_R3_ext");

    // R4 sum mode extremes, R3 aux cleared
    ext = 0; eqm = 2'd2;
    r0 = 16'h7FFF; r1 = 16'h7FFF; x0 = 16'h8000; x1 = 16'h8000;
    fire("R4_R3_sum_max");
    r0 = 16'h0005; r1 = 16'hFFFD; x0 = 16'hFFFF; x1 = 16'hFFFF;
    fire("R4_sum_mixed");

    // R5 element 0 larger
    eqm = 2'd0; q0 = 12'd100; q1 = 12'd50;
    r0 = 16'h8001; r1 = 16'h0011; x0 = 16'h1234; x1 = 16'h0022;
    fire("R5_pick0");

    // R6 element 1 larger
    q0 = 12'h000; q1 = 12'hFFF;
    r1 = 16'h0042; x1 = 16'hF000;
    fire("R6_pick1");

    // R7 tie
    q0 = 12'h800; q1 = 12'h800;
    fire("R7_tie");

    // R8 other codes
    eqm = 2'd1; q0 = 12'h010; q1 = 12'h011;
    fire("R8_code1");
    eqm = 2'd3; q0 = 12'h400; q1 = 12'h3FF;
    fire("R8_code3");

    // R9 hold without strobe
    ext = 1; eqm = 2'd2; mr = 17'h0AAAA; mx = 17'h15555; ma = 17'h00001; mb = 17'h00002;
    r0 = 16'h1111; r1 = 16'h2222; q1 = 12'hFFF;
    repeat (4) @(negedge clk);
    last.tag = "R9_hold";
    chk_all(last);

    // R10 creep halt in host mode, then strobe while halted
    fire("R10_load");
    creep = 1;
    @(negedge clk);
    z.tag = "R10_halt";
    chk_all(z);
    mr = 17'h00ABC; mx = 17'h1F00F; ma = 17'h00077; mb = 17'h00088;
    fire("R10_strobe_in_halt");
    creep = 0;
    @(negedge clk);
    last.tag = "R10_release";
    chk_all(last);

    // R10 halt under internal control
    ext = 0; eqm = 2'd0; q0 = 12'h001; q1 = 12'h000; r0 = 16'h0123; x0 = 16'h0456;
    fire("R10_int_load");
    creep = 1;
    @(negedge clk);
    z.tag = "R10_int_halt";
    chk_all(z);
    creep = 0;
    @(negedge clk);
    last.tag = "R10_int_release";
    chk_all(last);

    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain: actual %0d expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule